// File: doc/BRIEF.md
# Integer Register File with Index-31 Aliasing

This block holds the integer architectural state of a 64-bit core: thirty-one general registers at indices 0 to 30, plus a stack pointer kept outside that array. Index 31 has no storage of its own. Each access port carries a mode bit. With the mode bit set, index 31 reaches the stack pointer. With it clear, index 31 is a zero register that reads as zero and drops writes.

The block has two combinational read ports and one clocked write port. A second write input updates the link register (index 30) for branch-with-link operations. Every port can select a 32-bit width. A 32-bit read returns the low half, zero-extended. A 32-bit write clears the upper half of its destination.

A fault output flags a stack pointer that breaks the 16-byte alignment rule whenever a read port uses it as a base.

Top module: `reg_alias_file`

## Requirements
- R1: A synchronous active-high reset clears all thirty-one general registers and the stack pointer to zero. After reset, every read returns zero.
- R2: A write to index 0..30 updates that register at the rising clock edge. Reads in the same cycle still return the old value. The new value appears from the next cycle.
- R3: A read of index 31 with its port's mode bit clear returns zero, whatever the stack pointer holds.
- R4: A write to index 31 with the write mode bit clear changes neither the stack pointer nor any general register.
- R5: Index 31 with the mode bit set reads and writes the stack pointer. The stack pointer is separate from all thirty-one general registers.
- R6: A 32-bit read (narrow bit = 1) returns bits 31:0 of the selected register on bits 31:0 of the output, with bits 63:32 driven to zero.
- R7: A 32-bit write (narrow bit = 1) stores bits 31:0 of the write data and sets bits 63:32 of the destination to zero.
- R8: A 32-bit write to index 31 with the write mode bit set loads the stack pointer with the zero-extended low 32 bits of the write data.
- R9: When the link-write enable is high, register 30 takes the full 64-bit link data at the next clock edge.
- R10: If the normal write port targets index 30 in the same cycle as a link write, the normal write port's value is stored.
- R11: The alignment fault is high exactly when at least one read port has index 31 with its mode bit set and stack-pointer bits 3:0 are nonzero. It does not depend on read width.
- R12: The mode bit has no effect for indices 0..30, on both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rdIdxA | input | 5 | Read port A register index |
| rdNarrowA | input | 1 | Read port A 32-bit width select |
| rdSpModeA | input | 1 | Read port A: index 31 means stack pointer |
| rdDataA | output | 64 | Read port A data |
| rdIdxB | input | 5 | Read port B register index |
| rdNarrowB | input | 1 | Read port B 32-bit width select |
| rdSpModeB | input | 1 | Read port B: index 31 means stack pointer |
| rdDataB | output | 64 | Read port B data |
| wrEn | input | 1 | Write port enable |
| wrIdx | input | 5 | Write port register index |
| wrNarrow | input | 1 | Write port 32-bit width select |
| wrSpMode | input | 1 | Write port: index 31 means stack pointer |
| wrData | input | 64 | Write port data |
| linkWrEn | input | 1 | Link register write enable |
| linkWrData | input | 64 | Link register write data |
| spAlignFault | output | 1 | Stack-pointer misalignment seen on a base read |

## Verification
Reads are combinational from stored state, so corrupted state shows up as soon as a read port selects the affected location. A write that went to the wrong place, kept stale upper bits, or leaked through the zero register shows up on the first read of that location after the clock edge that committed it.

A write that lands in the stack pointer by mistake is also visible without any read of it: the fault output changes in any cycle where a port reads index 31 in stack-pointer mode and the low bits are nonzero. The scoreboard therefore reads back the location touched by each write, and its neighbours, in the cycle right after the write, and compares the fault output on every cycle.

// File: rtl/rf_pkg.sv
package rf_pkg;

  localparam int XLEN    = 64;
  localparam int IDX_W   = 5;
  localparam int NUM_RD  = 2;

  // Write-side strobes from control to datapath
  typedef struct packed {
    logic             gprWe;
    logic [IDX_W-1:0] gprIdx;
    logic             spWe;
    logic             narrow;
    logic             linkWe;
  } wrCtl_t;

  // Per read port selection from control to datapath
  typedef struct packed {
    logic             selSp;
    logic             selZero;
    logic             narrow;
    logic [IDX_W-1:0] idx;
  } rdCtl_t;

endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import rf_pkg::*;
#(
  parameter int IDX_BITS  = rf_pkg::IDX_W,
  parameter int RD_PORTS  = rf_pkg::NUM_RD,
  parameter int LINK_IDX  = 30
) (
  input  logic [RD_PORTS-1:0][IDX_BITS-1:0] rdIdx,
  input  logic [RD_PORTS-1:0]               rdNarrow,
  input  logic [RD_PORTS-1:0]               rdSpMode,
  input  logic                              wrEn,
  input  logic [IDX_BITS-1:0]               wrIdx,
  input  logic                              wrNarrow,
  input  logic                              wrSpMode,
  input  logic                              linkWrEn,
  output rdCtl_t [RD_PORTS-1:0]             rdCtl,
  output wrCtl_t                            wrCtl
);

  localparam logic [IDX_BITS-1:0] ALIAS_IDX = '1;
  localparam logic [IDX_BITS-1:0] LINK_SEL  = IDX_BITS'(LINK_IDX);

  // Index 31 resolves per port: stack pointer in base mode, zero otherwise
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    logic isAlias;
    assign isAlias  = (rdIdx[p] == ALIAS_IDX);
    assign rdCtl[p] = '{selSp:   isAlias &  rdSpMode[p],
                        selZero: isAlias & ~rdSpMode[p],
                        narrow:  rdNarrow[p],
                        idx:     rdIdx[p]};
  end

  logic wrAlias;
  logic gprWe;
  assign wrAlias = (wrIdx == ALIAS_IDX);
  assign gprWe   = wrEn & ~wrAlias;

  // Normal port outranks the link port on register 30
  assign wrCtl = '{gprWe:  gprWe,
                   gprIdx: wrIdx,
                   spWe:   wrEn & wrAlias & wrSpMode,
                   narrow: wrNarrow,
                   linkWe: linkWrEn & ~(gprWe & (wrIdx == LINK_SEL))};

endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import rf_pkg::*;
#(
  parameter int DATA_W     = rf_pkg::XLEN,
  parameter int IDX_BITS   = rf_pkg::IDX_W,
  parameter int RD_PORTS   = rf_pkg::NUM_RD,
  parameter int LINK_IDX   = 30,
  parameter int ALIGN_BITS = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  rdCtl_t [RD_PORTS-1:0]            rdCtl,
  input  wrCtl_t                           wrCtl,
  input  logic [DATA_W-1:0]                wrData,
  input  logic [DATA_W-1:0]                linkData,
  output logic [RD_PORTS-1:0][DATA_W-1:0]  rdData,
  output logic                             spAlignFault
);

  localparam int NUM_GPR = (2 ** IDX_BITS) - 1;
  localparam int HALF_W  = DATA_W / 2;

  logic [DATA_W-1:0] wrVal;
  logic [DATA_W-1:0] gprQ [NUM_GPR];
  logic [DATA_W-1:0] spQ;

  assign wrVal = wrCtl.narrow ? {{(DATA_W-HALF_W){1'b0}}, wrData[HALF_W-1:0]} : wrData;

  for (genvar i = 0; i < NUM_GPR; i++) begin : g_gpr
    logic [DATA_W-1:0] q;
    logic              hit;
    assign hit = wrCtl.gprWe && (wrCtl.gprIdx == IDX_BITS'(i));
    if (i == LINK_IDX) begin : g_link
      always_ff @(posedge clk) begin
        if (rst)              q <= '0;
        else if (hit)         q <= wrVal;
        else if (wrCtl.linkWe) q <= linkData;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (hit) q <= wrVal;
      end
    end
    assign gprQ[i] = q;
  end

  always_ff @(posedge clk) begin
    if (rst)              spQ <= '0;
    else if (wrCtl.spWe)  spQ <= wrVal;
  end

  logic spMisaligned;
  assign spMisaligned = |spQ[ALIGN_BITS-1:0];

  logic [RD_PORTS-1:0] portFault;

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    logic [DATA_W-1:0] raw;
    always_comb begin
      raw = '0;
      if (rdCtl[p].selSp) begin
        raw = spQ;
      end else if (!rdCtl[p].selZero) begin
        for (int j = 0; j < NUM_GPR; j++) begin
          if (rdCtl[p].idx == IDX_BITS'(j)) raw = gprQ[j];
        end
      end
    end
    assign rdData[p]    = rdCtl[p].narrow ? {{(DATA_W-HALF_W){1'b0}}, raw[HALF_W-1:0]} : raw;
    assign portFault[p] = rdCtl[p].selSp & spMisaligned;
  end

  assign spAlignFault = |portFault;

endmodule

// File: rtl/reg_alias_file.sv
module reg_alias_file
  import rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rdIdxA,
  input  logic             rdNarrowA,
  input  logic             rdSpModeA,
  output logic [XLEN-1:0]  rdDataA,
  input  logic [IDX_W-1:0] rdIdxB,
  input  logic             rdNarrowB,
  input  logic             rdSpModeB,
  output logic [XLEN-1:0]  rdDataB,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrNarrow,
  input  logic             wrSpMode,
  input  logic [XLEN-1:0]  wrData,
  input  logic             linkWrEn,
  input  logic [XLEN-1:0]  linkWrData,
  output logic             spAlignFault
);

  localparam int LINK_REG = 30;

  rdCtl_t [NUM_RD-1:0]            rdCtl;
  wrCtl_t                         wrCtl;
  logic [NUM_RD-1:0][XLEN-1:0]    rdData;

  rf_ctrl #(
    .IDX_BITS (IDX_W),
    .RD_PORTS (NUM_RD),
    .LINK_IDX (LINK_REG)
  ) i_ctrl (
    .rdIdx    ({rdIdxB, rdIdxA}),
    .rdNarrow ({rdNarrowB, rdNarrowA}),
    .rdSpMode ({rdSpModeB, rdSpModeA}),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .wrNarrow (wrNarrow),
    .wrSpMode (wrSpMode),
    .linkWrEn (linkWrEn),
    .rdCtl    (rdCtl),
    .wrCtl    (wrCtl)
  );

  rf_datapath #(
    .DATA_W     (XLEN),
    .IDX_BITS   (IDX_W),
    .RD_PORTS   (NUM_RD),
    .LINK_IDX   (LINK_REG),
    .ALIGN_BITS (4)
  ) i_dp (
    .clk          (clk),
    .rst          (rst),
    .rdCtl        (rdCtl),
    .wrCtl        (wrCtl),
    .wrData       (wrData),
    .linkData     (linkWrData),
    .rdData       (rdData),
    .spAlignFault (spAlignFault)
  );

  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];

endmodule

// File: rtl/reg_alias_file_chk.sv
module reg_alias_file_chk (
  input logic        clk,
  input logic        rst,
  input logic [4:0]  rdIdxA,
  input logic        rdNarrowA,
  input logic        rdSpModeA,
  input logic [63:0] rdDataA,
  input logic [4:0]  rdIdxB,
  input logic        rdNarrowB,
  input logic        rdSpModeB,
  input logic [63:0] rdDataB,
  input logic        wrEn,
  input logic [4:0]  wrIdx,
  input logic        wrNarrow,
  input logic        wrSpMode,
  input logic [63:0] wrData,
  input logic        linkWrEn,
  input logic [63:0] linkWrData,
  input logic        spAlignFault
);

  a_r3_zero_read: assert property (@(posedge clk) disable iff (rst)
    (rdIdxB == 5'd31 && !rdSpModeB) |-> (rdDataB == 64'd0));

  a_r6_narrow_upper: assert property (@(posedge clk) disable iff (rst)
    rdNarrowA |-> (rdDataA[63:32] == 32'd0));

  a_r2_write_visible: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && wrEn && wrIdx != 5'd31 && !wrNarrow) &&
     rdIdxA == $past(wrIdx) && !rdNarrowA) |-> (rdDataA == $past(wrData)));

  a_r8_sp_write: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && wrEn && wrIdx == 5'd31 && wrSpMode) &&
     rdIdxA == 5'd31 && rdSpModeA && !rdNarrowA) |->
    (rdDataA == ($past(wrNarrow) ? {32'd0, $past(wrData[31:0])} : $past(wrData))));

  a_r9_link_write: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && linkWrEn && !(wrEn && wrIdx == 5'd30)) &&
     rdIdxB == 5'd30 && !rdNarrowB) |-> (rdDataB == $past(linkWrData)));

  a_r11_fault_source: assert property (@(posedge clk) disable iff (rst)
    spAlignFault |-> ((rdIdxA == 5'd31 && rdSpModeA) || (rdIdxB == 5'd31 && rdSpModeB)));

  a_r11_fault_seen: assert property (@(posedge clk) disable iff (rst)
    (rdIdxA == 5'd31 && rdSpModeA && rdDataA[3:0] != 4'd0) |-> spAlignFault);

endmodule

bind reg_alias_file reg_alias_file_chk i_chk (
  .clk          (clk),
  .rst          (rst),
  .rdIdxA       (rdIdxA),
  .rdNarrowA    (rdNarrowA),
  .rdSpModeA    (rdSpModeA),
  .rdDataA      (rdDataA),
  .rdIdxB       (rdIdxB),
  .rdNarrowB    (rdNarrowB),
  .rdSpModeB    (rdSpModeB),
  .rdDataB      (rdDataB),
  .wrEn         (wrEn),
  .wrIdx        (wrIdx),
  .wrNarrow     (wrNarrow),
  .wrSpMode     (wrSpMode),
  .wrData       (wrData),
  .linkWrEn     (linkWrEn),
  .linkWrData   (linkWrData),
  .spAlignFault (spAlignFault)
);

// File: tb/test_reg_alias_file.sv
`timescale 1ns/1ps
module test_reg_alias_file;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rdIdxA = '0, rdIdxB = '0, wrIdx = '0;
  logic        rdNarrowA = 0, rdSpModeA = 0, rdNarrowB = 0, rdSpModeB = 0;
  logic        wrEn = 0, wrNarrow = 0, wrSpMode = 0, linkWrEn = 0;
  logic [63:0] wrData = '0, linkWrData = '0;
  logic [63:0] rdDataA, rdDataB;
  logic        spAlignFault;

  always #2.5 clk = ~clk;

  reg_alias_file i_reg_alias_file (.*);

  typedef struct {
    logic [63:0] expA;
    logic [63:0] expB;
    logic        expF;
    string       tag;
  } item_t;

  item_t       sbQ[$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  logic [63:0] mGpr [31];
  logic [63:0] mSp;

  function automatic logic [63:0] modelRead(input logic [4:0] idx, input logic nar, input logic spm);
    logic [63:0] v;
    if (idx == 5'd31) v = spm ? mSp : 64'd0;
    else              v = mGpr[idx];
    return nar ? {32'd0, v[31:0]} : v;
  endfunction

  // Driver: apply one cycle of stimulus, push expectations, update the model
  task automatic step(input string tag,
                      input logic [4:0] ra, input logic na, input logic sa,
                      input logic [4:0] rb, input logic nb, input logic sb,
                      input logic we, input logic [4:0] wi, input logic wn, input logic ws,
                      input logic [63:0] wd, input logic le, input logic [63:0] ld);
    item_t it;
    logic [63:0] wv;
    @(negedge clk);
    rdIdxA = ra; rdNarrowA = na; rdSpModeA = sa;
    rdIdxB = rb; rdNarrowB = nb; rdSpModeB = sb;
    wrEn = we; wrIdx = wi; wrNarrow = wn; wrSpMode = ws; wrData = wd;
    linkWrEn = le; linkWrData = ld;
    it.expA = modelRead(ra, na, sa);
    it.expB = modelRead(rb, nb, sb);
    it.expF = (mSp[3:0] != 4'd0) && ((ra == 5'd31 && sa) || (rb == 5'd31 && sb));
    it.tag  = tag;
    sbQ.push_back(it);
    wv = wn ? {32'd0, wd[31:0]} : wd;
    if (le && !(we && wi == 5'd30)) mGpr[30] = ld;
    if (we) begin
      if (wi != 5'd31) mGpr[wi] = wv;
      else if (ws)     mSp = wv;
    end
  endtask

  task automatic rd(input string tag, input logic [4:0] ra, input logic na, input logic sa,
                    input logic [4:0] rb, input logic nb, input logic sb);
    step(tag, ra, na, sa, rb, nb, sb, 1'b0, 5'd0, 1'b0, 1'b0, 64'd0, 1'b0, 64'd0);
  endtask

  task automatic wr(input string tag, input logic [4:0] wi, input logic wn, input logic ws,
                    input logic [63:0] wd);
    step(tag, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, wi, wn, ws, wd, 1'b0, 64'd0);
  endtask

  // Monitor: compare just before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sbQ.size() > 0) begin
        item_t it;
        it = sbQ.pop_front();
        checks++;
        if (rdDataA !== it.expA || rdDataB !== it.expB || spAlignFault !== it.expF) begin
          errors++;
          $display("FAIL %s: A=%h exp %h B=%h exp %h fault=%b exp %b",
                   it.tag, rdDataA, it.expA, rdDataB, it.expB, spAlignFault, it.expF);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 31; i++) mGpr[i] = '0;
    mSp = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd("R1", 5'd0, 0, 0, 5'd30, 0, 0);
    rd("R1", 5'd31, 0, 1, 5'd17, 0, 0);

    // R2: same-cycle invisible, next-cycle visible
    step("R2", 5'd3, 0, 0, 5'd4, 0, 0, 1, 5'd3, 0, 0, 64'h1122334455667788, 0, 64'd0);
    rd("R2", 5'd3, 0, 0, 5'd2, 0, 0);

    // R5: stack pointer separate, reachable in base mode
    wr("R5", 5'd31, 0, 1, 64'h0000_7FFF_FFFF_FF00);
    rd("R5", 5'd31, 0, 1, 5'd0, 0, 0);
    wr("R5", 5'd0, 0, 0, 64'h5555_5555_5555_5555);
    rd("R5", 5'd31, 0, 1, 5'd0, 0, 0);

    // R3: index 31 with mode clear reads zero even with nonzero SP
    rd("R3", 5'd31, 0, 0, 5'd31, 1, 0);

    // R4: write to zero register discarded
    wr("R4", 5'd31, 0, 0, 64'hDEAD_BEEF_DEAD_BEEF);
    rd("R4", 5'd31, 0, 1, 5'd31, 0, 0);
    rd("R4", 5'd0, 0, 0, 5'd30, 0, 0);

    // R6: narrow read
    wr("R6", 5'd7, 0, 0, 64'hAAAA_BBBB_CCCC_DDDD);
    rd("R6", 5'd7, 1, 0, 5'd7, 0, 0);

    // R7: narrow write clears upper half
    wr("R7", 5'd7, 1, 0, 64'hFFFF_0000_1234_5678);
    rd("R7", 5'd7, 0, 0, 5'd3, 0, 0);

    // R8: narrow write to SP
    wr("R8", 5'd31, 1, 1, 64'h1234_5678_0000_0040);
    rd("R8", 5'd31, 0, 1, 5'd31, 1, 1);

    // R11: alignment fault
    wr("R11", 5'd31, 0, 1, 64'h0000_0000_0000_1008);
    rd("R11", 5'd31, 0, 1, 5'd1, 0, 0);
    rd("R11", 5'd31, 0, 0, 5'd31, 0, 0);
    rd("R11", 5'd2, 0, 0, 5'd31, 1, 1);
    wr("R11", 5'd31, 0, 1, 64'h0000_0000_0000_1010);
    rd("R11", 5'd31, 0, 1, 5'd31, 0, 1);

    // R9: link write
    step("R9", 5'd0, 0, 0, 5'd0, 0, 0, 0, 5'd0, 0, 0, 64'd0, 1, 64'hCAFE_F00D_0BAD_C0DE);
    rd("R9", 5'd30, 0, 0, 5'd30, 1, 0);

    // R10: normal write beats link write on register 30
    step("R10", 5'd0, 0, 0, 5'd0, 0, 0, 1, 5'd30, 0, 0, 64'h0123_4567_89AB_CDEF, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R10", 5'd30, 0, 0, 5'd29, 0, 0);
    step("R10", 5'd0, 0, 0, 5'd0, 0, 0, 1, 5'd30, 1, 0, 64'h9999_9999_0000_0123, 1, 64'h7777_7777_7777_7777);
    rd("R10", 5'd30, 0, 0, 5'd31, 0, 1);
    // link still lands when normal write targets another register
    step("R9", 5'd0, 0, 0, 5'd0, 0, 0, 1, 5'd12, 0, 0, 64'h0000_0000_0000_0ABC, 1, 64'h4444_3333_2222_1111);
    rd("R9", 5'd30, 0, 0, 5'd12, 0, 0);

    // R12: mode bit ignored below index 31
    wr("R12", 5'd4, 0, 1, 64'h0F0F_0F0F_F0F0_F0F0);
    rd("R12", 5'd4, 0, 1, 5'd31, 0, 1);

    // Mixed traffic against the model
    for (int n = 0; n < 300; n++) begin
      logic [31:0] r;
      r = $urandom;
      step("R2", 5'($urandom), r[0], r[1], 5'($urandom), r[2], r[3],
           r[4], 5'($urandom), r[5], r[6], {$urandom, $urandom},
           r[7] & r[8], {$urandom, $urandom});
    end

    rd("R2", 5'd0, 0, 0, 5'd0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule